// File: doc/BRIEF.md
# Bus Target Transfer and Disconnect Controller

This block is the control state machine of a PCI target. It claims a transaction when the master starts one and the address decode hits. It paces each data phase against a back end that may not be ready, and it ends a burst early with a disconnect that carries data when the back end asks for that. The bus strobes are active-low single-bit ports: FRAME#, IRDY#, DEVSEL#, TRDY# and STOP#. The back end sees a ready level, a last-word request and a one-cycle transfer strobe.

After a disconnect the block waits in backoff and holds STOP# low. It leaves backoff only on a clock where the FRAME# pin itself is sampled high. It never leaves after a fixed single cycle. A master that keeps FRAME# low for many cycles after STOP# therefore cannot push the machine back into a data phase. Configuration space, parity, master mode and address sequencing are handled elsewhere.

Top module: `pci_tgt_term`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, the block returns to idle after that edge: `devsel_n`, `trdy_n` and `stop_n` go high (1 = deasserted) and `xfer_stb` goes low (1 = strobe).
- R2: A claim happens only when `frame_n` is sampled low at an edge, was sampled high at the previous edge, and `addr_hit` is 1 at that edge. `devsel_n` then goes low after the following edge, so DEVSEL# appears one clock after the address phase. A miss produces no claim, and so does `addr_hit` rising while FRAME# is already held low.
- R3: `trdy_n` goes low only after an edge at which `irdy_n` was sampled low within the current data phase and `be_ready` was 1. While `be_ready` is 0, TRDY# stays high and wait states are inserted.
- R4: A data phase completes at an edge where `irdy_n` and `trdy_n` are both low. After that edge `xfer_stb` is 1 for exactly one cycle and `trdy_n` is high for at least one cycle.
- R5: When `be_last` is sampled at 1 during a transaction, `stop_n` goes low in the same cycle that `trdy_n` goes low for the next data phase. This is a disconnect with data.
- R6: After the disconnect phase completes, the block is in backoff: `trdy_n` is high, and `stop_n` and `devsel_n` stay low for every cycle in which `frame_n` is still sampled low, however many cycles that is.
- R7: Backoff ends at the first edge where the raw `frame_n` input is sampled high, and `stop_n` is high after that edge.
- R8: When `frame_n` and `irdy_n` are both sampled high during a claimed transaction, the bus is idle. `devsel_n`, `trdy_n` and `stop_n` are all high after that edge.
- R9: `devsel_n` stays low from the claim until the bus is idle, and `trdy_n` is never low while `devsel_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Raw FRAME# from the bus, active low |
| irdy_n | input | 1 | Raw IRDY# from the bus, active low |
| addr_hit | input | 1 | Address decode hit, valid during the address phase |
| be_ready | input | 1 | Back end can complete a data phase |
| be_last | input | 1 | Back end requests that the next phase be the last |
| devsel_n | output | 1 | DEVSEL#, active low |
| trdy_n | output | 1 | TRDY#, active low |
| stop_n | output | 1 | STOP#, active low |
| xfer_stb | output | 1 | One-cycle pulse per completed data phase |

## Verification
All outputs come straight from state flops, so a wrong state shows at the pins one clock after the edge that caused it. Two examples:
- If the machine left backoff too early, STOP# would rise while FRAME# is still held low.
- If the machine drifted back into a data phase, TRDY# would reappear after the disconnect.

The sweeps hold FRAME# low for zero to several cycles after STOP#. They also vary the wait states and the position of the last word, so the machine is caught in the cycle its outputs go wrong.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DECODE  = 3'd1,
    ST_DATA    = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_DRAIN   = 3'd4
  } tgt_state_e;

  // data phase completes when both ready strobes are low at the edge
  function automatic logic phase_done(input logic irdy_n, input logic trdy_on);
    return (!irdy_n) && trdy_on;
  endfunction

  // neither FRAME# nor IRDY# driven low
  function automatic logic bus_idle(input logic frame_n, input logic irdy_n);
    return frame_n && irdy_n;
  endfunction

  // states in which the target has claimed the bus
  function automatic logic devsel_on(input tgt_state_e st);
    return (st == ST_DATA) || (st == ST_BACKOFF) || (st == ST_DRAIN);
  endfunction

endpackage

// File: rtl/tgt_claim_det.sv
module tgt_claim_det (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic addr_hit,
  output logic claim
);
  logic frame_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_prev <= 1'b1;
    else        frame_prev <= frame_n;
  end

  // newly asserted FRAME# plus a decode hit
  assign claim = frame_prev && !frame_n && addr_hit;

  // a held-low FRAME# cannot claim twice in a row (R2)
  p_claim_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> !claim);

endmodule

// File: rtl/tgt_term_fsm.sv
module tgt_term_fsm
  import pci_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       claim,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       done,
  input  logic       stop_on,
  output tgt_state_e state
);
  tgt_state_e state_d;
  logic       idle_w;

  assign idle_w = bus_idle(frame_n, irdy_n);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:    if (claim) state_d = ST_DECODE;
      ST_DECODE:  state_d = idle_w ? ST_IDLE : ST_DATA;
      ST_DATA: begin
        if (idle_w)              state_d = ST_IDLE;
        else if (done && stop_on) state_d = ST_BACKOFF;
      end
      // exit decided from the raw FRAME# pin, never on a fixed count
      ST_BACKOFF: if (frame_n) state_d = irdy_n ? ST_IDLE : ST_DRAIN;
      ST_DRAIN:   if (idle_w)  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  p_backoff_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACKOFF && !frame_n) |=> (state == ST_BACKOFF));

  p_backoff_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACKOFF && frame_n) |=> (state != ST_BACKOFF));

  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DATA || state == ST_DRAIN) && frame_n && irdy_n) |=> (state == ST_IDLE));

endmodule

// File: rtl/tgt_hs_ctl.sv
module tgt_hs_ctl
  import pci_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tgt_state_e state,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       be_ready,
  input  logic       be_last,
  input  logic       done,
  output logic       trdy_on,
  output logic       stop_on,
  output logic       xfer_stb
);
  logic trdy_d, stop_d, pend_q, pend_d, pend_any, xfer_d;

  assign pend_any = pend_q || be_last;

  always_comb begin
    trdy_d = 1'b0;
    stop_d = 1'b0;
    pend_d = pend_q;
    case (state)
      ST_DATA: begin
        if (!bus_idle(frame_n, irdy_n)) begin
          trdy_d = !done && (trdy_on || (!irdy_n && be_ready));
          stop_d = stop_on || (trdy_d && !trdy_on && pend_any);
        end
        if (be_last)            pend_d = 1'b1;
        if (stop_d && !stop_on) pend_d = 1'b0;
      end
      ST_DECODE:  if (be_last) pend_d = 1'b1;
      ST_BACKOFF: stop_d = !frame_n;
      default:    pend_d = 1'b0;
    endcase
  end

  assign xfer_d = (state == ST_DATA) && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trdy_on  <= 1'b0;
      stop_on  <= 1'b0;
      pend_q   <= 1'b0;
      xfer_stb <= 1'b0;
    end else begin
      trdy_on  <= trdy_d;
      stop_on  <= stop_d;
      pend_q   <= pend_d;
      xfer_stb <= xfer_d;
    end
  end

  p_trdy_after_irdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy_on) |-> $past(!irdy_n));

  p_trdy_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !trdy_on);

  p_xfer_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |=> !xfer_stb);

  p_stop_with_trdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_on) |-> trdy_on);

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_on && !frame_n) |=> stop_on);

endmodule

// File: rtl/pci_tgt_term.sv
module pci_tgt_term
  import pci_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic addr_hit,
  input  logic be_ready,
  input  logic be_last,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic xfer_stb
);
  tgt_state_e state;
  logic claim_w, done_w, trdy_on, stop_on;

  assign done_w = phase_done(irdy_n, trdy_on);

  tgt_claim_det claim_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .addr_hit (addr_hit),
    .claim    (claim_w)
  );

  tgt_term_fsm fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .claim   (claim_w),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .done    (done_w),
    .stop_on (stop_on),
    .state   (state)
  );

  tgt_hs_ctl hs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .be_ready (be_ready),
    .be_last  (be_last),
    .done     (done_w),
    .trdy_on  (trdy_on),
    .stop_on  (stop_on),
    .xfer_stb (xfer_stb)
  );

  assign devsel_n = !devsel_on(state);
  assign trdy_n   = !trdy_on;
  assign stop_n   = !stop_on;

  p_reset_release_r1: assert property (@(posedge clk)
    !rst_n |=> (devsel_n && trdy_n && stop_n && !xfer_stb));

  p_trdy_inside_devsel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

endmodule

// File: tb/pci_tgt_term_tb.sv
module pci_tgt_term_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, addr_hit = 1'b0, be_ready = 1'b0, be_last = 1'b0;
  logic devsel_n, trdy_n, stop_n, xfer_stb;
  int   tests = 0, fails = 0, cycles = 0;

  pci_tgt_term dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .addr_hit(addr_hit), .be_ready(be_ready), .be_last(be_last),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .xfer_stb(xfer_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WD_LIMIT) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one claimed transaction; last_at > 0 makes that phase a disconnect with data
  task automatic run_txn(input int nwait, input int nph, input int last_at, input int hold);
    int phases;
    phases = (last_at > 0) ? last_at : nph;
    frame_n = 1'b1; irdy_n = 1'b1; step(); step();
    frame_n = 1'b0; addr_hit = 1'b1; step();
    chk("R2", "devsel at address edge", devsel_n, 1'b1);
    addr_hit = 1'b0; irdy_n = 1'b0;
    if (phases == 1 && last_at == 0) frame_n = 1'b1;
    step();
    chk("R2", "devsel one clock after address", devsel_n, 1'b0);
    chk("R3", "no trdy in decode", trdy_n, 1'b1);
    for (int p = 1; p <= phases; p++) begin
      be_ready = (nwait == 0);
      be_last  = (p == last_at);
      if (p > 1 && p == phases && last_at == 0) frame_n = 1'b1;
      for (int w = 0; w < nwait; w++) begin
        step(); be_last = 1'b0;
        chk("R3", "wait state holds trdy", trdy_n, 1'b1);
        chk("R9", "devsel held in wait", devsel_n, 1'b0);
        if (w == nwait - 1) be_ready = 1'b1;
      end
      step(); be_last = 1'b0;
      chk("R3", "trdy after irdy and ready", trdy_n, 1'b0);
      chk("R5", "stop with trdy", stop_n, (p == last_at) ? 1'b0 : 1'b1);
      step();
      chk("R4", "xfer strobe", xfer_stb, 1'b1);
      chk("R4", "trdy gap after completion", trdy_n, 1'b1);
      if (p == last_at) chk("R6", "stop held entering backoff", stop_n, 1'b0);
      if (p == phases && last_at == 0) irdy_n = 1'b1;
    end
    if (last_at == 0) begin
      step();
      chk("R8", "devsel released on idle", devsel_n, 1'b1);
      chk("R4", "strobe single cycle", xfer_stb, 1'b0);
    end else begin
      for (int h = 0; h < hold; h++) begin
        step();
        chk("R6", "stop held while frame low", stop_n, 1'b0);
        chk("R6", "trdy off in backoff", trdy_n, 1'b1);
        chk("R9", "devsel held in backoff", devsel_n, 1'b0);
      end
      frame_n = 1'b1;
      irdy_n  = (hold % 2 == 0) ? 1'b1 : 1'b0;
      step();
      chk("R7", "stop released on frame high", stop_n, 1'b1);
      if (irdy_n) chk("R8", "all released", devsel_n, 1'b1);
      else begin
        chk("R9", "devsel held while irdy low", devsel_n, 1'b0);
        irdy_n = 1'b1; step();
        chk("R8", "devsel released on idle", devsel_n, 1'b1);
      end
    end
  endtask

  initial begin
    step(); step();
    chk("R1", "devsel in reset", devsel_n, 1'b1);
    chk("R1", "trdy in reset", trdy_n, 1'b1);
    chk("R1", "stop in reset", stop_n, 1'b1);
    chk("R1", "strobe in reset", xfer_stb, 1'b0);
    rst_n = 1'b1; step();

    // miss, then a hit that arrives while FRAME# is already low
    frame_n = 1'b0; addr_hit = 1'b0; step(); step(); step();
    chk("R2", "miss not claimed", devsel_n, 1'b1);
    addr_hit = 1'b1; step(); step(); step();
    chk("R2", "held frame not claimed", devsel_n, 1'b1);
    chk("R9", "no trdy unclaimed", trdy_n, 1'b1);
    addr_hit = 1'b0; frame_n = 1'b1; step();

    for (int nw = 0; nw <= 2; nw++)
      for (int np = 1; np <= 3; np++)
        for (int la = 0; la <= np; la++)
          for (int hd = 0; hd <= ((la > 0) ? 4 : 0); hd++)
            run_txn(nw, np, la, hd);

    // long FRAME# hold after the disconnect
    run_txn(0, 1, 1, 40);

    // reset during a disconnect phase
    frame_n = 1'b0; addr_hit = 1'b1; step();
    addr_hit = 1'b0; irdy_n = 1'b0; be_ready = 1'b1; be_last = 1'b1; step();
    step(); be_last = 1'b0;
    chk("R5", "stop with trdy before reset", stop_n, 1'b0);
    rst_n = 1'b0; step();
    chk("R1", "devsel after mid reset", devsel_n, 1'b1);
    chk("R1", "trdy after mid reset", trdy_n, 1'b1);
    chk("R1", "stop after mid reset", stop_n, 1'b1);
    rst_n = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; step(); step();
    chk("R2", "no claim without new frame", devsel_n, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule